// File: doc/BRIEF.md
# Serial Disk Word Assembler

This block sits between a serial disk data path and the word-oriented side of a disk controller. On the read side it gathers serial bits into 16-bit words. On the write side it emits a 16-bit word one bit at a time, most significant bit first. A bit is consumed only on a bit tick. The tick comes either from a recovered-data clock enable or from a local crystal clock enable, and a command bit can force the crystal source. Each completed word produces a one-cycle ready pulse that wakes the word task. A command bit can suppress that pulse.

Word boundaries are framed by a bit counter. While the run-free command bit (`wait_one`) is low and the counter is in its hold state (minus one), ticks carrying a 0 are ignored. The first tick carrying a 1 is taken as the last bit of the sync mark, and counting starts with the next bit. Clearing `wait_one` after it was set re-arms this hold. A transfer-off command freezes all bit activity and silences the serial output.

Top module: `ds_word_assembler`

## Requirements
- R1: While in the hold state with `wait_one` low, a tick carrying `ser_in`=0 leaves the block in hold. A tick carrying `ser_in`=1 leaves hold without storing that bit, and the next tick supplies data bit 0 of a word.
- R2: While `wait_one` is high, a tick in the hold state leaves hold whatever `ser_in` is, and every later tick advances the bit index. Once hold has been left, it is not re-entered except as in R3.
- R3: On the clock edge where `wait_one` is seen low after being high in the previous cycle, the block returns to hold and discards any partial word. This takes priority over a tick in the same cycle.
- R4: While `xfer_off` is 1, ticks are ignored: `rd_word`, the bit count and the write shift register keep their values, `word_ready` stays 0 and `ser_out` is 0.
- R5: While `word_wake_inh` is 1 on the cycle of a word's final tick, no `word_ready` pulse is produced for that word. `rd_word` is still updated.
- R6: The bit tick is `xtal_bit_en` when `force_xtal` is 1, and `rec_bit_en` otherwise.
- R7: On the 16th data tick of a word, `rd_word` is loaded in the following cycle. The first data bit received lands in bit 15, and the last lands in bit 0. `word_ready` is high for exactly that one cycle.
- R8: The write shift register loads `wr_word` on the tick that leaves hold and on each 16th data tick. On other data ticks it shifts left by one. `ser_out` equals its bit 15 when `wr_mode` is 1, the block is not in hold and `xfer_off` is 0. Otherwise `ser_out` is 0.
- R9: After reset the block is in hold, `rd_word` is 0, `word_ready` is 0 and `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial read data, sampled on a bit tick |
| rec_bit_en | input | 1 | Bit enable from recovered disk clock |
| xtal_bit_en | input | 1 | Bit enable from crystal clock |
| force_xtal | input | 1 | 1 selects the crystal bit enable |
| wait_one | input | 1 | 0 arms hold-until-first-1; 1 lets the counter run |
| xfer_off | input | 1 | 1 blocks all data movement |
| word_wake_inh | input | 1 | 1 suppresses the word-ready pulse |
| wr_mode | input | 1 | 1 drives write data onto `ser_out` |
| wr_word | input | 16 | Next word to be written |
| rd_word | output | 16 | Last assembled read word |
| word_ready | output | 1 | One-cycle word-task wakeup |
| ser_out | output | 1 | Serial write data |

## Verification
The assertions assume that both bit enables are single-cycle strobes sampled on the system clock. They also assume the command inputs are synchronous to `clk`. The hold check relies on `wait_one` staying steady across the cycle it inspects. The stimulus drives every input shortly after the falling edge, so each value is stable at the next rising edge. It toggles `wait_one` randomly only in the phase that exercises re-arming. The other phases keep `wait_one` constant, so releases come only from 1-bits or from the run setting.

// File: rtl/ds_pkg.sv
package ds_pkg;
    localparam int WORD_W = 16;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic xfer_off;
        logic wake_inh;
        logic force_xtal;
        logic wait_one;
        logic wr_mode;
    } cmd_t;

    function automatic logic pick_tick(input cmd_t c, input logic rec_en, input logic xtal_en);
        return ~c.xfer_off & (c.force_xtal ? xtal_en : rec_en);
    endfunction
endpackage

// File: rtl/ds_bitclk_sel.sv
module ds_bitclk_sel
    import ds_pkg::*;
(
    input  cmd_t cmd,
    input  logic rec_bit_en,
    input  logic xtal_bit_en,
    output logic tick
);
    always_comb tick = pick_tick(cmd, rec_bit_en, xtal_bit_en);
endmodule

// File: rtl/ds_bit_counter.sv
module ds_bit_counter #(
    parameter int WORD_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic                      ser_in,
    input  logic                      wait_one,
    output logic                      hold,
    output logic                      rearm,
    output logic                      start,
    output logic                      data_tick,
    output logic                      boundary
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

    logic             wait_q;
    logic [IDX_W-1:0] idx;

    always_comb begin
        rearm     = wait_q & ~wait_one;
        start     = tick & hold & ~rearm & (ser_in | wait_one);
        data_tick = tick & ~hold & ~rearm;
        boundary  = data_tick & (idx == LAST);
    end

    always_ff @(posedge clk) wait_q <= wait_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= 1'b1;
            idx  <= '0;
        end else if (rearm) begin
            hold <= 1'b1;
            idx  <= '0;
        end else if (start) begin
            hold <= 1'b0;
            idx  <= '0;
        end else if (data_tick) begin
            idx <= boundary ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/ds_word_shifter.sv
module ds_word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic              data_tick,
    input  logic              boundary,
    input  logic              ser_in,
    input  logic              wake_inh,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word,
    output logic              ready,
    output logic              tx_msb
);
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_next;

    always_comb begin
        rx_next = {rx_sh[WORD_W-2:0], ser_in};
        tx_msb  = tx_sh[WORD_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh   <= '0;
            rd_word <= '0;
            ready   <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (clr) begin
                rx_sh <= '0;
            end else if (data_tick) begin
                rx_sh <= rx_next;
                if (boundary) begin
                    rd_word <= rx_next;
                    ready   <= ~wake_inh;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tx_sh <= '0;
        else if (load)
            tx_sh <= wr_word;
        else if (data_tick)
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
    end
endmodule

// File: rtl/ds_word_assembler.sv
module ds_word_assembler
    import ds_pkg::*;
#(
    parameter int W = ds_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_in,
    input  logic         rec_bit_en,
    input  logic         xtal_bit_en,
    input  logic         force_xtal,
    input  logic         wait_one,
    input  logic         xfer_off,
    input  logic         word_wake_inh,
    input  logic         wr_mode,
    input  logic [W-1:0] wr_word,
    output logic [W-1:0] rd_word,
    output logic         word_ready,
    output logic         ser_out
);
    cmd_t cmd;
    logic tick;
    logic cnt_hold;
    logic rearm;
    logic start;
    logic data_tick;
    logic boundary;
    logic tx_msb;

    always_comb begin
        cmd.xfer_off   = xfer_off;
        cmd.wake_inh   = word_wake_inh;
        cmd.force_xtal = force_xtal;
        cmd.wait_one   = wait_one;
        cmd.wr_mode    = wr_mode;
    end

    ds_bitclk_sel u_sel (
        .cmd         (cmd),
        .rec_bit_en  (rec_bit_en),
        .xtal_bit_en (xtal_bit_en),
        .tick        (tick)
    );

    ds_bit_counter #(.WORD_W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .ser_in    (ser_in),
        .wait_one  (cmd.wait_one),
        .hold      (cnt_hold),
        .rearm     (rearm),
        .start     (start),
        .data_tick (data_tick),
        .boundary  (boundary)
    );

    ds_word_shifter #(.WORD_W(W)) u_shf (
        .clk       (clk),
        .rst       (rst),
        .clr       (rearm),
        .load      (start | boundary),
        .data_tick (data_tick),
        .boundary  (boundary),
        .ser_in    (ser_in),
        .wake_inh  (cmd.wake_inh),
        .wr_word   (wr_word),
        .rd_word   (rd_word),
        .ready     (word_ready),
        .tx_msb    (tx_msb)
    );

    always_comb ser_out = cmd.wr_mode & ~cmd.xfer_off & ~cnt_hold & tx_msb;
endmodule

// File: rtl/ds_word_assembler_chk.sv
module ds_word_assembler_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         in_hold,
    input logic         ser_in,
    input logic         wait_one,
    input logic         xfer_off,
    input logic         word_wake_inh,
    input logic         word_ready,
    input logic [W-1:0] rd_word,
    input logic         ser_out
);
    a_r1_hold_on_zero: assert property (@(posedge clk) disable iff (rst)
        (in_hold && tick && !ser_in && !wait_one) |=> in_hold);

    a_r2_run_leaves_hold: assert property (@(posedge clk) disable iff (rst)
        (in_hold && tick && wait_one) |=> !in_hold);

    a_r2_stay_running: assert property (@(posedge clk) disable iff (rst)
        (!in_hold && wait_one) |=> !in_hold);

    a_r3_rearm: assert property (@(posedge clk) disable iff (rst)
        (!wait_one && $past(wait_one)) |=> in_hold);

    a_r4_no_wake_when_off: assert property (@(posedge clk) disable iff (rst)
        xfer_off |=> !word_ready);

    a_r4_word_frozen: assert property (@(posedge clk) disable iff (rst)
        xfer_off |=> $stable(rd_word));

    a_r4_quiet_output: assert property (@(posedge clk) disable iff (rst)
        xfer_off |-> !ser_out);

    a_r5_inhibit: assert property (@(posedge clk) disable iff (rst)
        word_wake_inh |=> !word_ready);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        word_ready |=> !word_ready);
endmodule

bind ds_word_assembler ds_word_assembler_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .in_hold       (cnt_hold),
    .ser_in        (ser_in),
    .wait_one      (wait_one),
    .xfer_off      (xfer_off),
    .word_wake_inh (word_wake_inh),
    .word_ready    (word_ready),
    .rd_word       (rd_word),
    .ser_out       (ser_out)
);

// File: tb/ds_word_assembler_tb.sv
module ds_word_assembler_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_in = 0, rec_bit_en = 0, xtal_bit_en = 0, force_xtal = 0;
    logic        wait_one = 0, xfer_off = 0, word_wake_inh = 0, wr_mode = 0;
    logic [15:0] wr_word = 0;
    logic [15:0] rd_word;
    logic        word_ready;
    logic        ser_out;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // behavioural model state
    bit          m_hold = 1;
    int          m_cnt  = 0;
    logic [15:0] m_rx = 0, m_tx = 0, m_rd = 0;
    bit          m_ready = 0;
    bit          m_wprev = 0;

    always #4 clk = ~clk;

    ds_word_assembler u_dut (
        .clk(clk), .rst(rst), .ser_in(ser_in), .rec_bit_en(rec_bit_en),
        .xtal_bit_en(xtal_bit_en), .force_xtal(force_xtal), .wait_one(wait_one),
        .xfer_off(xfer_off), .word_wake_inh(word_wake_inh), .wr_mode(wr_mode),
        .wr_word(wr_word), .rd_word(rd_word), .word_ready(word_ready), .ser_out(ser_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit exp_so;
        exp_so = wr_mode && !xfer_off && !m_hold && m_tx[15];
        check(rd_word == m_rd, "R7/R1/R2/R3/R6 rd_word", rd_word, m_rd);
        check(word_ready == m_ready, "R7/R5/R4 word_ready", word_ready, m_ready);
        check(ser_out == exp_so, "R8/R4 ser_out", ser_out, exp_so);
    endtask

    task automatic model_step();
        bit tk, fl;
        tk = !xfer_off && (force_xtal ? xtal_bit_en : rec_bit_en);   // R6
        fl = m_wprev && !wait_one;                                    // R3
        m_ready = 0;
        if (rst) begin
            m_hold = 1; m_cnt = 0; m_rx = 0; m_tx = 0; m_rd = 0;
        end else if (fl) begin
            m_hold = 1; m_cnt = 0; m_rx = 0;
        end else if (tk) begin
            if (m_hold) begin
                if (ser_in || wait_one) begin                         // R1, R2
                    m_hold = 0; m_cnt = 0; m_tx = wr_word;
                end
            end else begin
                m_rx = {m_rx[14:0], ser_in};
                if (m_cnt == 15) begin
                    m_rd = m_rx; m_ready = !word_wake_inh; m_cnt = 0; m_tx = wr_word;
                end else begin
                    m_cnt++; m_tx = {m_tx[14:0], 1'b0};
                end
            end
        end
        m_wprev = wait_one;
    endtask

    task automatic cycle();
        @(negedge clk);
        #1;
        if (!rst) compare();
        model_step();
    endtask

    task automatic phase(input int n, input int p_rec, input int p_xtal, input int p_one,
                         input bit fx, input int p_off, input int p_inh, input bit wr,
                         input bit wbase, input int p_wflip);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rec_bit_en    = ($urandom % 100) < p_rec;
            xtal_bit_en   = ($urandom % 100) < p_xtal;
            ser_in        = ($urandom % 100) < p_one;
            force_xtal    = fx;
            xfer_off      = ($urandom % 100) < p_off;
            word_wake_inh = ($urandom % 100) < p_inh;
            wr_mode       = wr;
            wr_word       = 16'($urandom);
            wait_one      = (($urandom % 100) < p_wflip) ? !wbase : wbase;
            #1;
            compare();
            model_step();
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        rst = 1;
        for (int i = 0; i < 4; i++) cycle();
        @(negedge clk);
        rst = 0;
        wr_mode = 1;
        #1;
        // R9: reset state
        check(rd_word == 16'h0, "R9 rd_word after reset", rd_word, 0);
        check(word_ready == 1'b0, "R9 word_ready after reset", word_ready, 0);
        check(ser_out == 1'b0, "R9 ser_out after reset", ser_out, 0);
        model_step();
        // R1: hold until first one, sparse ones, recovered clock
        phase(1500, 50, 0, 10, 0, 0, 0, 0, 0, 0);
        // R2, R7: free running, dense ticks, varied data
        phase(1500, 90, 0, 50, 0, 0, 0, 0, 1, 0);
        // R6: crystal forced, recovered enable is noise
        phase(1500, 50, 70, 50, 1, 0, 0, 1, 1, 0);
        // R4: transfer-off bursts while writing
        phase(1500, 80, 0, 50, 0, 30, 0, 1, 1, 0);
        // R5: wakeup inhibit
        phase(1500, 90, 0, 50, 0, 0, 50, 0, 1, 0);
        // R3: run setting toggled, re-arming the hold
        phase(2000, 80, 40, 30, 0, 5, 10, 1, 1, 4);
        // R8: serial write stream, every cycle a tick
        phase(1500, 100, 0, 50, 0, 0, 0, 1, 1, 0);
        // R1 again with crystal clock and transfer-off mixed in
        phase(1500, 0, 60, 5, 1, 10, 0, 1, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule